// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a 32-bit RISC core whose instructions are all 32 bits wide. On every clock edge it loads the address of the next instruction to fetch. That address is one of three candidates:

- the sequential address, which is the current PC plus 4;
- a PC-relative conditional-branch target;
- a pseudo-direct jump target.

The block also drives PC+4 as an output, so the datapath can write it into a link register.

The opcode is decoded outside this block. The decoder supplies three strobes: jump, branch-if-equal and branch-if-not-equal. The register file supplies an equality flag. The block receives the low 26 bits of the fetched instruction word. The branch offset is in bits 15:0 and the jump index is in bits 25:0.

Each cycle a selector picks one of four named states:

- `SEL_HOLD`: stall asserted.
- `SEL_JUMP`: jump strobe asserted.
- `SEL_BRANCH`: a branch condition is met.
- `SEL_SEQ`: otherwise.

The selector works in that priority order. The state register then loads the target that the chosen state names. The transition into each state depends only on that cycle's inputs. A synchronous reset overrides all of this and loads the start address given by the parameter `RESET_ADDR`.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` becomes `RESET_ADDR` (default 0x0040_0000), whatever `stall` and the strobes are doing.
- R2: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32.
- R3: With `stall`, `jump`, `br_eq` and `br_ne` all low, the PC advances by 4 at each edge, wrapping from 0xFFFF_FFFC to 0.
- R4: When `br_eq` and `regs_equal` are both high, the next PC is (PC + 4) + (sign-extended `insn_lo[15:0]` × 4).
- R5: When `br_ne` is high and `regs_equal` is low, the next PC is the same branch target as in R4.
- R6: A branch strobe whose condition fails (`br_eq` with `regs_equal` low, or `br_ne` with `regs_equal` high) gives the next PC as PC + 4.
- R7: The 16-bit offset is two's complement. Offset 0x8000 moves the PC back by 131072 from PC + 4, offset 0x7FFF moves it forward by 131068, and the sum wraps modulo 2^32.
- R8: When `jump` is high, the next PC is {PC[31:28], `insn_lo[25:0]`, 2'b00}, where PC is the current PC.
- R9: Priority is jump, then a taken branch, then PC + 4.
- R10: When `stall` is high and `rst` is low, the PC keeps its value even if a jump or taken branch is requested.
- R11: The selected address appears on `pc_o` one clock edge after the inputs that chose it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the PC for this cycle |
| jump | input | 1 | Decoded jump strobe |
| br_eq | input | 1 | Decoded branch-if-equal strobe |
| br_ne | input | 1 | Decoded branch-if-not-equal strobe |
| regs_equal | input | 1 | The two compared registers are equal |
| insn_lo | input | 26 | Bits 25:0 of the fetched instruction |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus 4 (link value) |

## Verification
`pc_o` is due exactly one rising edge after the inputs that chose it. `pc_plus4_o` is due in the same cycle as the `pc_o` it depends on.

The bench changes inputs on the falling edge. It lets one rising edge pass, then reads both outputs on the following falling edge. So every comparison sees the result of exactly one register update.

The expected PC for each vector comes from a table chained by hand from the reset address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        SEL_HOLD   = 2'd0,
        SEL_JUMP   = 2'd1,
        SEL_BRANCH = 2'd2,
        SEL_SEQ    = 2'd3
    } pcu_sel_e;

endpackage

// File: rtl/pcu_targets.sv
module pcu_targets #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 26,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [IDX_W-1:0]  insn_field,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] branch_addr,
    output logic [ADDR_W-1:0] jump_addr
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;
    localparam int TOP_W = ADDR_W - IDX_W - 2;

    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] offset_scaled;

    assign offset        = insn_field[OFF_W-1:0];
    assign offset_scaled = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};

    always_comb begin
        seq_addr    = pc_cur + ADDR_W'(4);
        branch_addr = seq_addr + offset_scaled;
        jump_addr   = {pc_cur[ADDR_W-1 -: TOP_W], insn_field, 2'b00};
    end

    // R7: offset word scaling keeps the target word aligned
    always_comb begin
        a_r7_branch_aligned: assert (branch_addr[1:0] == pc_cur[1:0]);
    end
endmodule

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
(
    input  logic     stall,
    input  logic     jump,
    input  logic     br_eq,
    input  logic     br_ne,
    input  logic     regs_equal,
    output pcu_sel_e sel
);
    logic take_branch;

    assign take_branch = (br_eq & regs_equal) | (br_ne & ~regs_equal);

    always_comb begin
        if (stall)            sel = SEL_HOLD;
        else if (jump)        sel = SEL_JUMP;
        else if (take_branch) sel = SEL_BRANCH;
        else                  sel = SEL_SEQ;
    end

    // R9: a jump request never yields the branch or sequential state
    always_comb begin
        a_r9_jump_wins: assert (!(jump && !stall) || sel == SEL_JUMP);
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          IDX_W      = 26,
    parameter int          OFF_W      = 16,
    parameter logic [31:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              jump,
    input  logic              br_eq,
    input  logic              br_ne,
    input  logic              regs_equal,
    input  logic [IDX_W-1:0]  insn_lo,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    localparam int TOP_W = ADDR_W - IDX_W - 2;

    pcu_sel_e          sel;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [ADDR_W-1:0] seq_addr, branch_addr, jump_addr;

    pcu_targets #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_targets (
        .pc_cur      (pc_q),
        .insn_field  (insn_lo),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr)
    );

    pcu_select u_select (
        .stall      (stall),
        .jump       (jump),
        .br_eq      (br_eq),
        .br_ne      (br_ne),
        .regs_equal (regs_equal),
        .sel        (sel)
    );

    always_comb begin
        unique case (sel)
            SEL_HOLD:   pc_d = pc_q;
            SEL_JUMP:   pc_d = jump_addr;
            SEL_BRANCH: pc_d = branch_addr;
            SEL_SEQ:    pc_d = seq_addr;
            default:    pc_d = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= ADDR_W'(RESET_ADDR);
        else     pc_q <= pc_d;
    end

    always_comb begin
        pc_o       = pc_q;
        pc_plus4_o = seq_addr;
    end

    // R1: reset loads the start address
    a_r1_reset_addr: assert property (@(posedge clk)
        rst |=> pc_q == ADDR_W'(RESET_ADDR));

    // R10: stall holds the PC
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> pc_q == $past(pc_q));

    // R8: jump keeps the top PC bits and is word aligned
    a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
        (jump && !stall) |=> (pc_q[1:0] == 2'b00 &&
            pc_q[ADDR_W-1 -: TOP_W] == $past(pc_q[ADDR_W-1 -: TOP_W])));

    // R3: no control request advances by one word
    a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!stall && !jump && !br_eq && !br_ne) |=> pc_q == $past(pc_q) + ADDR_W'(4));

    // R6: failed branch-equal condition falls through
    a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
        (!stall && !jump && br_eq && !br_ne && !regs_equal) |=> pc_q == $past(pc_q) + ADDR_W'(4));
endmodule

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0, jump = 1'b0, br_eq = 1'b0, br_ne = 1'b0, regs_equal = 1'b0;
    logic [25:0] insn_lo = '0;
    logic [31:0] pc_o, pc_plus4_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pc_next_unit uut (
        .clk(clk), .rst(rst), .stall(stall), .jump(jump), .br_eq(br_eq),
        .br_ne(br_ne), .regs_equal(regs_equal), .insn_lo(insn_lo),
        .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
    );

    // {stall, jump, br_eq, br_ne, regs_equal, insn_lo[25:0], expected pc}
    localparam int NV = 14;
    localparam logic [62:0] VEC [NV] = '{
        {5'b00000, 26'h0000000, 32'h0040_0004},  // R3 sequential
        {5'b00101, 26'h0000003, 32'h0040_0014},  // R4 beq taken
        {5'b00100, 26'h0000003, 32'h0040_0018},  // R6 beq not taken
        {5'b00010, 26'h000FFFE, 32'h0040_0014},  // R5 bne taken, backward
        {5'b00011, 26'h0000003, 32'h0040_0018},  // R6 bne not taken
        {5'b01000, 26'h0100000, 32'h0040_0000},  // R8 jump
        {5'b01101, 26'h0000040, 32'h0000_0100},  // R9 jump beats taken branch
        {5'b11000, 26'h0000040, 32'h0000_0100},  // R10 stall beats jump
        {5'b10000, 26'h0000000, 32'h0000_0100},  // R10 plain stall
        {5'b00101, 26'h0008000, 32'hFFFE_0104},  // R7 most negative offset
        {5'b00000, 26'h0000000, 32'hFFFE_0108},  // R3 sequential
        {5'b01000, 26'h3FFFFFF, 32'hFFFF_FFFC},  // R8 top bits kept
        {5'b00000, 26'h0000000, 32'h0000_0000},  // R3 wrap
        {5'b00101, 26'h0007FFF, 32'h0002_0000}   // R7 most positive offset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] ctl, input logic [25:0] fld);
        {stall, jump, br_eq, br_ne, regs_equal} = ctl;
        insn_lo = fld;
        @(negedge clk);   // R11: one rising edge passes before sampling
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_o, 32'h0040_0000);
        check("R2 reset link", pc_plus4_o, 32'h0040_0004);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][62:58], VEC[i][57:32]);
            check("R11 vector pc", pc_o, VEC[i][31:0]);
            check("R2 vector link", pc_plus4_o, VEC[i][31:0] + 32'd4);
        end

        // R1: reset wins over stall and jump mid-run
        rst = 1'b1;
        step(5'b11000, 26'h3FFFFFF);
        check("R1 reset overrides stall", pc_o, 32'h0040_0000);
        rst = 1'b0;

        // R4: zero offset lands on PC+4
        step(5'b00101, 26'h0000000);
        check("R4 zero offset", pc_o, 32'h0040_0004);

        // R9: bne taken while beq strobe fails still branches
        step(5'b00110, 26'h0000001);
        check("R9 bne with beq", pc_o, 32'h0040_000C);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule